// File: doc/BRIEF.md
# SPI Chip-Select Line Driver

This block owns the chip-select pins of an SPI master. A small set of select lines, six by default and fewer in reduced builds, each hold a raw state bit. Software changes these bits with single writes to a forcing port. The upper half of the forcing word carries a set strobe per line and the lower half carries a clear strobe per line. One line can therefore be asserted or released without disturbing its neighbours and without a read-modify-write.

A separate configuration word marks, per line, whether the line is in use as a chip select and whether its pin is inverted. Inversion suits devices whose select is active high. A line that is not in use drives its inactive level. The raw state of every line is visible as a status word. After reset every raw bit is one, so an active-low select starts released. The configuration is all zero after reset.

Top module: `spi_cs_driver`

## Requirements
- R1: After reset the status word is all ones and every pin is high. The configuration holds zero: no line enabled and no line inverted.
- R2: A forcing write with bit 8+n set and bit n clear makes the raw state of line n one from the next clock edge.
- R3: A forcing write with bit n set and bit 8+n clear makes the raw state of line n zero from the next clock edge.
- R4: A line keeps its raw state when both of its strobe bits are written as one, when both are written as zero, or when no forcing write is made.
- R5: For a line whose enable bit (configuration bit 8+n) is one, the pin equals the raw state XOR the inversion bit (configuration bit n).
- R6: For a line whose enable bit is zero, the pin holds the inactive level, which is the inverse of its inversion bit, whatever its raw state.
- R7: The configuration changes only on a configuration write and takes effect from the next clock edge. Forcing writes never alter it.
- R8: A forcing write of 0xFF00 sets every raw bit to one, so every enabled non-inverted pin goes high.
- R9: Strobe and configuration bits that belong to lines at or above the line count are ignored and change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: enable per line in bits 8 and up, inversion per line in bits 0 and up |
| force_we | input | 1 | Forcing write strobe |
| force_wdata | input | 16 | Forcing word: set strobes in bits 8 and up, clear strobes in bits 0 and up |
| cs_pin_o | output | NUM_SEL | Chip-select pins |
| cs_state_o | output | NUM_SEL | Status word: raw state of each line |

## Verification
A write presented before a rising edge is captured on that edge. Both the status word and the pins show its effect immediately after that edge, with no further register stage. The bench changes inputs on falling edges and compares both outputs at the following falling edge, one full cycle after the write was presented. Held writes, writes with both strobes set and writes to absent lines are checked the same way. Each is checked at the edge where a wrong design would first differ.

// File: rtl/spi_cs_pkg.sv
// Shared constants and helpers for the chip-select line driver.
// Assumes a write word split into two equal halves of SEL_FIELD_W bits.
package spi_cs_pkg;
    localparam int SEL_FIELD_W = 8;
    localparam int SEL_WORD_W  = 2 * SEL_FIELD_W;
    localparam int SEL_MAX     = 6;

    // Next raw state of one line given its set and clear strobes.
    function automatic logic sel_next(input logic cur, input logic set_s, input logic clr_s);
        logic nxt;
        nxt = cur;
        if (set_s && !clr_s) nxt = 1'b1;
        if (clr_s && !set_s) nxt = 1'b0;
        return nxt;
    endfunction
endpackage

// File: rtl/spi_cs_cfg_reg.sv
// Configuration register: an enable bit and an inversion bit per line.
// Assumes enable bits sit in the upper half of the word and inversion
// bits in the lower half, one bit per line from bit zero of each half.
module spi_cs_cfg_reg
    import spi_cs_pkg::*;
#(
    parameter int NUM_SEL = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SEL_WORD_W-1:0] wdata,
    output logic [NUM_SEL-1:0]    en_q,
    output logic [NUM_SEL-1:0]    inv_q
);
    // Capture the per-line fields on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            inv_q <= '0;
        end else if (we) begin
            en_q  <= wdata[SEL_FIELD_W +: NUM_SEL];
            inv_q <= wdata[0 +: NUM_SEL];
        end
    end
endmodule

// File: rtl/spi_cs_line.sv
// One chip-select line: raw state flop plus pin shaping.
// Assumes the strobes are already qualified by the write enable.
module spi_cs_line
    import spi_cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_s,
    input  logic clr_s,
    input  logic en_i,
    input  logic inv_i,
    output logic raw_q,
    output logic pin_o
);
    // Raw state: resets released (one), moves on a lone strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b1;
        else        raw_q <= sel_next(raw_q, set_s, clr_s);
    end

    // Pin: follows raw state with optional inversion, or idles when unused.
    always_comb begin
        if (en_i) pin_o = raw_q ^ inv_i;
        else      pin_o = ~inv_i;
    end
endmodule

// File: rtl/spi_cs_driver.sv
// Top of the chip-select line driver: configuration register and one
// line slice per select. Assumes NUM_SEL is between 1 and SEL_MAX.
module spi_cs_driver
    import spi_cs_pkg::*;
#(
    parameter int NUM_SEL = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [SEL_WORD_W-1:0] cfg_wdata,
    input  logic                  force_we,
    input  logic [SEL_WORD_W-1:0] force_wdata,
    output logic [NUM_SEL-1:0]    cs_pin_o,
    output logic [NUM_SEL-1:0]    cs_state_o
);
    logic [NUM_SEL-1:0] en_q;
    logic [NUM_SEL-1:0] inv_q;
    logic [NUM_SEL-1:0] set_vec;
    logic [NUM_SEL-1:0] clr_vec;
    logic               unused_spare;

    // Spare bits of both words belong to absent lines and are dropped.
    assign unused_spare = ^{cfg_wdata, force_wdata};

    // Qualify the strobe halves with the forcing write enable.
    always_comb begin
        set_vec = force_we ? force_wdata[SEL_FIELD_W +: NUM_SEL] : '0;
        clr_vec = force_we ? force_wdata[0 +: NUM_SEL] : '0;
    end

    spi_cs_cfg_reg #(.NUM_SEL(NUM_SEL)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .en_q  (en_q),
        .inv_q (inv_q)
    );

    for (genvar n = 0; n < NUM_SEL; n++) begin : g_line
        spi_cs_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .set_s (set_vec[n]),
            .clr_s (clr_vec[n]),
            .en_i  (en_q[n]),
            .inv_i (inv_q[n]),
            .raw_q (cs_state_o[n]),
            .pin_o (cs_pin_o[n])
        );
    end
endmodule

// File: rtl/spi_cs_driver_chk.sv
// Property checker for the chip-select line driver, bound to the top.
// Assumes it sees the configuration register outputs of the top scope.
module spi_cs_driver_chk
    import spi_cs_pkg::*;
#(
    parameter int NUM_SEL = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic                  force_we,
    input logic [SEL_WORD_W-1:0] force_wdata,
    input logic [NUM_SEL-1:0]    cs_state_o,
    input logic [NUM_SEL-1:0]    en_q,
    input logic [NUM_SEL-1:0]    inv_q
);
    for (genvar n = 0; n < NUM_SEL; n++) begin : g_prop
        // R2: lone set strobe raises the raw state.
        a_r2_set_line: assert property (@(posedge clk) disable iff (!rst_n)
            (force_we && force_wdata[SEL_FIELD_W+n] && !force_wdata[n]) |=> cs_state_o[n]);
        // R3: lone clear strobe lowers the raw state.
        a_r3_clear_line: assert property (@(posedge clk) disable iff (!rst_n)
            (force_we && force_wdata[n] && !force_wdata[SEL_FIELD_W+n]) |=> !cs_state_o[n]);
        // R4: both strobes together hold the raw state.
        a_r4_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (force_we && force_wdata[n] && force_wdata[SEL_FIELD_W+n]) |=> $stable(cs_state_o[n]));
    end

    // R4: without a forcing write no line moves.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !force_we |=> $stable(cs_state_o));

    // R8: all-set word releases every line.
    a_r8_all_release: assert property (@(posedge clk) disable iff (!rst_n)
        (force_we && force_wdata == 16'hFF00) |=> (cs_state_o == {NUM_SEL{1'b1}}));

    // R7: configuration moves only on its own write.
    a_r7_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable({en_q, inv_q}));
endmodule

bind spi_cs_driver spi_cs_driver_chk #(.NUM_SEL(NUM_SEL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .force_we    (force_we),
    .force_wdata (force_wdata),
    .cs_state_o  (cs_state_o),
    .en_q        (en_q),
    .inv_q       (inv_q)
);

// File: tb/spi_cs_driver_bench.sv
// Bench for the chip-select line driver: directed corners then seeded random.
module spi_cs_driver_bench;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [15:0]  cfg_wdata = '0;
    logic         force_we = 1'b0;
    logic [15:0]  force_wdata = '0;
    logic [N-1:0] cs_pin_o;
    logic [N-1:0] cs_state_o;

    int checks = 0;
    int fails = 0;
    logic [N-1:0] m_raw = '1;
    logic [N-1:0] m_en = '0;
    logic [N-1:0] m_inv = '0;

    always #5 clk = ~clk;

    spi_cs_driver #(.NUM_SEL(N)) u_spi_cs_driver (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .force_we(force_we), .force_wdata(force_wdata),
        .cs_pin_o(cs_pin_o), .cs_state_o(cs_state_o)
    );

    function automatic logic [N-1:0] next_raw(input logic [N-1:0] cur, input logic [15:0] w);
        logic [N-1:0] r;
        for (int n = 0; n < N; n++) begin
            r[n] = cur[n];
            if (w[8+n] && !w[n]) r[n] = 1'b1;
            if (w[n] && !w[8+n]) r[n] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] pins(input logic [N-1:0] raw, input logic [N-1:0] en,
                                          input logic [N-1:0] inv);
        logic [N-1:0] p;
        for (int n = 0; n < N; n++) p[n] = en[n] ? (raw[n] ^ inv[n]) : ~inv[n];
        return p;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of writes, then compare both outputs one edge later.
    task automatic step(input logic cw, input logic [15:0] cd, input logic fw,
                        input logic [15:0] fd, input string req);
        cfg_we = cw; cfg_wdata = cd; force_we = fw; force_wdata = fd;
        @(posedge clk);
        @(negedge clk);
        if (cw) begin m_en = cd[8 +: N]; m_inv = cd[0 +: N]; end
        if (fw) m_raw = next_raw(m_raw, fd);
        check({req, " state"}, cs_state_o, m_raw);
        check({req, " pin"}, cs_pin_o, pins(m_raw, m_en, m_inv));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", cs_state_o, '1);
        check("R1 reset pin", cs_pin_o, '1);
        step(1'b0, 16'h0, 1'b1, 16'h0001, "R3 R6 clear while unused");
        check("R6 unused pin idle", cs_pin_o, '1);
        step(1'b1, 16'h3F00, 1'b0, 16'h0, "R7 R5 enable all");
        step(1'b0, 16'h0, 1'b1, 16'h0100, "R2 set line0");
        step(1'b0, 16'h0, 1'b1, 16'h0002, "R3 clear line1");
        step(1'b0, 16'h0, 1'b1, 16'h0202, "R4 both strobes line1");
        step(1'b0, 16'h0, 1'b0, 16'h003F, "R4 no write");
        step(1'b0, 16'h0, 1'b1, 16'h00C0, "R9 clear absent lines");
        step(1'b0, 16'h0, 1'b1, 16'hC000, "R9 set absent lines");
        step(1'b1, 16'h3F05, 1'b0, 16'h0, "R5 inverted lines");
        step(1'b1, 16'hCA05, 1'b1, 16'h003C, "R6 R7 R9 partial enable");
        step(1'b0, 16'h0, 1'b1, 16'hFF00, "R8 release all");
        check("R8 all raw high", cs_state_o, '1);
        step(1'b1, 16'h3F00, 1'b0, 16'h0, "R8 R5 enabled pins high");
        check("R8 pins high", cs_pin_o, '1);
        for (int i = 0; i < 400; i++) begin
            logic [15:0] cd = 16'($urandom);
            logic [15:0] fd = ($urandom % 8 == 0) ? 16'hFF00 : 16'($urandom);
            step(($urandom % 4) == 0, cd, ($urandom % 2) == 0, fd, "R2 R3 R4 R5 R6 R7 random");
        end
        cfg_we = 1'b0; force_we = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule